// File: doc/BRIEF.md
# Multi-Mode Quadrature Encoder Counter

This block turns the two channels of an incremental encoder (A and B) and its index line into a position count. The channels can be read as a step pulse plus a direction level, or as a quadrature pair decoded at one, two or four counts per cycle. The count register behaves in one of four ways at its limits: it wraps freely, stops after one overflow, saturates between zero and a preset, or rolls over modulo a preset. The width of the active count can be one to four bytes. A preset register feeds the range and modulo limits, the compare flag and the load action. A latch register captures a snapshot of the count.

Two 8-bit mode words and the preset are written through a simple strobe-and-data port. Command strobes clear or load the count, latch it, and clear the flags. The index line can load, clear or latch the count. It acts either on the sampled input or directly on the raw edge. Four sticky flags (carry, borrow, compare, index) each have their own enable. All inputs are taken as already synchronous to the clock.

Top module: `quad_enc_counter`

## Requirements
- R1: When mode word 0 bits [1:0] = 0 (step/direction), a rising edge on A changes the count by one: up when B is low, down when B is high. A falling edge on A and any change on B leave the count unchanged.
- R2: When bits [1:0] = 1 (1x), the count steps only on a rising edge of A: up when B is low, down when B is high. One full forward quadrature cycle adds exactly one count.
- R3: When bits [1:0] = 2 (2x), the count steps on both edges of A. One full quadrature cycle gives two counts.
- R4: When bits [1:0] = 3 (4x), every single edge on A or B is counted, so a full cycle gives four counts. A transition in which A and B change together leaves the count unchanged.
- R5: When mode word 0 bits [3:2] = 0 (free-running), the count wraps through the range chosen by mode word 1 bits [1:0] (number of bytes minus one). Going from the maximum to zero raises carry, and going from zero to the maximum raises borrow.
- R6: When bits [3:2] = 1 (single-cycle), the counter stops after the first carry or borrow. It counts again only after a clear or a load.
- R7: When bits [3:2] = 2 (range-limit), the count never goes above the preset or below zero, in either direction.
- R8: When bits [3:2] = 3 (modulo), the count runs through preset+1 states: up from the preset gives zero, and down from zero gives the preset.
- R9: The index rising edge takes the action set by mode word 0 bits [5:4]: 0 none, 1 load the preset into the count, 2 clear the count, 3 copy the count into the latch register.
- R10: With mode word 0 bit 6 = 0, the index action lands two clock edges after the index rises. With bit 6 = 1 and a quadrature decode, it lands one edge after. In step/direction mode, bit 6 is ignored and the two-edge timing is used.
- R11: When mode word 1 bit 2 is set, counting stops and the count holds.
- R12: The flags are sticky until flag_clr and are enabled one by one: carry by mode word 1 bit 3, borrow by bit 4, compare by bit 5, index by bit 6. The compare flag is set one edge after the count equals the preset.
- R13: When mode word 0 bit 7 is set, the inputs are sampled only on every second clock. A level held for two clocks is still counted exactly once.
- R14: dtr_wr writes the preset, cntr_load copies the preset into the count, cntr_clr clears the count, and otr_load copies the count into the latch register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_a | input | 1 | Encoder channel A (or step) |
| ch_b | input | 1 | Encoder channel B (or direction) |
| ch_idx | input | 1 | Encoder index |
| cfg_wr | input | 1 | Mode word write strobe |
| cfg_sel | input | 1 | 0 selects mode word 0, 1 selects mode word 1 |
| cfg_wdata | input | 8 | Mode word data |
| dtr_wr | input | 1 | Preset write strobe |
| dtr_wdata | input | CNT_W | Preset data |
| cntr_clr | input | 1 | Clear the count |
| cntr_load | input | 1 | Load the preset into the count |
| otr_load | input | 1 | Copy the count into the latch register |
| flag_clr | input | 1 | Clear all flags |
| cnt_val | output | CNT_W | Current count |
| otr_val | output | CNT_W | Latched count |
| flag_carry | output | 1 | Sticky carry flag |
| flag_borrow | output | 1 | Sticky borrow flag |
| flag_cmp | output | 1 | Sticky compare flag |
| flag_idx | output | 1 | Sticky index flag |

## Verification
With the divider off, a channel change made before an edge shows in the count and in carry/borrow after that one edge. Strobes and mode writes also take effect at the next edge. The compare flag follows the count by one more edge. The index action lands after two edges when synchronous and after one when asynchronous. The bench checks the edge before and the edge of each of these to pin the latency. With the divider on, the sampling phase is not known to the bench, so each level is held for two clocks and the count is read only after both.

// File: rtl/qec_pkg.sv
package qec_pkg;
    typedef enum logic [1:0] {DEC_STEPDIR, DEC_X1, DEC_X2, DEC_X4} dec_mode_e;
    typedef enum logic [1:0] {CM_FREE, CM_SINGLE, CM_RANGE, CM_MODULO} cnt_mode_e;
    typedef enum logic [1:0] {IX_NONE, IX_LOAD, IX_CLEAR, IX_LATCH} idx_act_e;

    // mode word 0: [7] sample divide, [6] async index, [5:4] index action,
    // [3:2] count mode, [1:0] decode scheme
    typedef struct packed {
        logic      filt_div2;
        logic      idx_async;
        idx_act_e  idx_act;
        cnt_mode_e cmode;
        dec_mode_e dec;
    } mode0_t;

    // mode word 1: [6] index flag en, [5] compare en, [4] borrow en,
    // [3] carry en, [2] count off, [1:0] bytes-1
    typedef struct packed {
        logic       en_idx;
        logic       en_cmp;
        logic       en_brw;
        logic       en_cry;
        logic       cnt_off;
        logic [1:0] len;
    } mode1_t;
endpackage

// File: rtl/qec_decoder.sv
module qec_decoder
    import qec_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ch_a,
    input  logic      ch_b,
    input  logic      ch_idx,
    input  dec_mode_e dec,
    input  logic      div2,
    input  logic      idx_async,
    output logic      step,
    output logic      up,
    output logic      idx_evt
);
    typedef struct packed {
        logic a_l;
        logic b_l;
        logic i_samp_l;
        logic i_raw_l;
        logic phase;
        logic isync;
    } dec_st_t;

    dec_st_t st_d, st_q;
    logic    tick, da, db;

    always_comb begin
        st_d         = st_q;
        st_d.phase   = ~st_q.phase;
        st_d.i_raw_l = ch_idx;
        st_d.isync   = 1'b0;
        tick         = ~div2 | st_q.phase;
        da           = ch_a ^ st_q.a_l;
        db           = ch_b ^ st_q.b_l;
        step         = 1'b0;
        up           = 1'b0;
        if (tick) begin
            st_d.a_l      = ch_a;
            st_d.b_l      = ch_b;
            st_d.i_samp_l = ch_idx;
            st_d.isync    = ch_idx & ~st_q.i_samp_l;
            case (dec)
                DEC_STEPDIR: begin step = ch_a & da;        up = ~ch_b;        end
                DEC_X1:      begin step = ch_a & da & ~db;  up = ~ch_b;        end
                DEC_X2:      begin step = da & ~db;         up = ch_a ^ ch_b;  end
                default:     begin
                    step = da ^ db;
                    up   = da ? (ch_a ^ ch_b) : ~(ch_a ^ ch_b);
                end
            endcase
        end
        if (idx_async && dec != DEC_STEPDIR)
            idx_evt = ch_idx & ~st_q.i_raw_l;
        else
            idx_evt = st_q.isync;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/qec_core.sv
module qec_core
    import qec_pkg::*;
#(
    parameter int CNT_BYTES = 4,
    localparam int CNT_W    = 8 * CNT_BYTES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             up,
    input  logic             idx_evt,
    input  mode0_t           m0,
    input  mode1_t           m1,
    input  logic [CNT_W-1:0] dtr,
    input  logic             cntr_clr,
    input  logic             cntr_load,
    input  logic             otr_load,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] otr,
    output logic [3:0]       flags
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] otr;
        logic             halted;
        logic             f_cry;
        logic             f_brw;
        logic             f_cmp;
        logic             f_idx;
    } core_st_t;

    core_st_t         q, d;
    logic [CNT_W-1:0] mask, lim, wrap_hi;
    logic             advance, ovr, cry, brw;
    logic             idx_load, idx_zero, idx_latch;

    always_comb begin
        mask = '0;
        for (int i = 0; i < CNT_BYTES; i++)
            if (i <= int'(m1.len)) mask[8*i +: 8] = 8'hFF;
        lim       = dtr & mask;
        wrap_hi   = (m0.cmode == CM_RANGE || m0.cmode == CM_MODULO) ? lim : mask;
        idx_load  = idx_evt && m0.idx_act == IX_LOAD;
        idx_zero  = idx_evt && m0.idx_act == IX_CLEAR;
        idx_latch = idx_evt && m0.idx_act == IX_LATCH;
        ovr       = cntr_clr | cntr_load | idx_load | idx_zero;
        advance   = step && !m1.cnt_off && !q.halted;
        cry       = 1'b0;
        brw       = 1'b0;
        d         = q;
        d.cnt     = q.cnt & mask;

        if (advance) begin
            if (up) begin
                if (q.cnt == wrap_hi) begin
                    cry   = 1'b1;
                    d.cnt = (m0.cmode == CM_RANGE) ? q.cnt : '0;
                end else begin
                    d.cnt = (q.cnt + 1'b1) & mask;
                end
            end else begin
                if (q.cnt == '0) begin
                    brw   = 1'b1;
                    d.cnt = (m0.cmode == CM_RANGE) ? q.cnt : wrap_hi;
                end else begin
                    d.cnt = (q.cnt - 1'b1) & mask;
                end
            end
            if (m0.cmode == CM_SINGLE && (cry || brw)) d.halted = 1'b1;
        end

        if (cntr_clr || idx_zero) begin
            d.cnt    = '0;
            d.halted = 1'b0;
        end else if (cntr_load || idx_load) begin
            d.cnt    = lim;
            d.halted = 1'b0;
        end

        if (otr_load || idx_latch) d.otr = q.cnt;

        if (flag_clr) begin
            d.f_cry = 1'b0;
            d.f_brw = 1'b0;
            d.f_cmp = 1'b0;
            d.f_idx = 1'b0;
        end
        if (m1.en_cry && cry && !ovr) d.f_cry = 1'b1;
        if (m1.en_brw && brw && !ovr) d.f_brw = 1'b1;
        if (m1.en_cmp && q.cnt == lim) d.f_cmp = 1'b1;
        if (m1.en_idx && idx_evt)      d.f_idx = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cnt   = q.cnt;
    assign otr   = q.otr;
    assign flags = {q.f_idx, q.f_cmp, q.f_brw, q.f_cry};

    assert_hold_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (m1.cnt_off && !ovr) |=> (q.cnt == $past(q.cnt & mask)));

    assert_single_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.halted && !ovr) |=> (q.cnt == $past(q.cnt & mask)));

    assert_range_ceiling_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (m0.cmode == CM_RANGE && advance && up && q.cnt == lim && !ovr) |=> $stable(q.cnt));

    assert_free_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (m0.cmode == CM_FREE && advance && up && q.cnt != mask && !ovr)
        |=> (q.cnt == (($past(q.cnt) + 1'b1) & $past(mask))));

    assert_mod_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (m0.cmode == CM_MODULO && advance && !ovr && q.cnt <= lim) |=> (q.cnt <= $past(lim)));

    assert_carry_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (q.f_cry && !flag_clr) |=> q.f_cry);
endmodule

// File: rtl/quad_enc_counter.sv
module quad_enc_counter
    import qec_pkg::*;
#(
    parameter int  CNT_BYTES = 4,
    localparam int CNT_W     = 8 * CNT_BYTES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ch_a,
    input  logic             ch_b,
    input  logic             ch_idx,
    input  logic             cfg_wr,
    input  logic             cfg_sel,
    input  logic [7:0]       cfg_wdata,
    input  logic             dtr_wr,
    input  logic [CNT_W-1:0] dtr_wdata,
    input  logic             cntr_clr,
    input  logic             cntr_load,
    input  logic             otr_load,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cnt_val,
    output logic [CNT_W-1:0] otr_val,
    output logic             flag_carry,
    output logic             flag_borrow,
    output logic             flag_cmp,
    output logic             flag_idx
);
    typedef struct packed {
        mode0_t           m0;
        mode1_t           m1;
        logic [CNT_W-1:0] dtr;
    } cfg_st_t;

    cfg_st_t    cfg_d, cfg_q;
    logic       step, up, idx_evt;
    logic [3:0] flags;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_wr && !cfg_sel) cfg_d.m0 = mode0_t'(cfg_wdata);
        if (cfg_wr &&  cfg_sel) cfg_d.m1 = mode1_t'(cfg_wdata[6:0]);
        if (dtr_wr)             cfg_d.dtr = dtr_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    qec_decoder u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .ch_a      (ch_a),
        .ch_b      (ch_b),
        .ch_idx    (ch_idx),
        .dec       (cfg_q.m0.dec),
        .div2      (cfg_q.m0.filt_div2),
        .idx_async (cfg_q.m0.idx_async),
        .step      (step),
        .up        (up),
        .idx_evt   (idx_evt)
    );

    qec_core #(.CNT_BYTES(CNT_BYTES)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .up        (up),
        .idx_evt   (idx_evt),
        .m0        (cfg_q.m0),
        .m1        (cfg_q.m1),
        .dtr       (cfg_q.dtr),
        .cntr_clr  (cntr_clr),
        .cntr_load (cntr_load),
        .otr_load  (otr_load),
        .flag_clr  (flag_clr),
        .cnt       (cnt_val),
        .otr       (otr_val),
        .flags     (flags)
    );

    assign {flag_idx, flag_cmp, flag_borrow, flag_carry} = flags;
endmodule

// File: tb/sim_quad_enc_counter.sv
module sim_quad_enc_counter;
    localparam int CLK_PERIOD = 10;
    localparam int W = 32;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ch_a = 0, ch_b = 0, ch_idx = 0;
    logic cfg_wr = 0, cfg_sel = 0;
    logic [7:0] cfg_wdata = '0;
    logic dtr_wr = 0;
    logic [W-1:0] dtr_wdata = '0;
    logic cntr_clr = 0, cntr_load = 0, otr_load = 0, flag_clr = 0;
    logic [W-1:0] cnt_val, otr_val;
    logic flag_carry, flag_borrow, flag_cmp, flag_idx;

    int checks = 0, errors = 0, ph = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    quad_enc_counter #(.CNT_BYTES(4)) u0 (
        .clk(clk), .rst_n(rst_n), .ch_a(ch_a), .ch_b(ch_b), .ch_idx(ch_idx),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .dtr_wr(dtr_wr), .dtr_wdata(dtr_wdata), .cntr_clr(cntr_clr),
        .cntr_load(cntr_load), .otr_load(otr_load), .flag_clr(flag_clr),
        .cnt_val(cnt_val), .otr_val(otr_val), .flag_carry(flag_carry),
        .flag_borrow(flag_borrow), .flag_cmp(flag_cmp), .flag_idx(flag_idx)
    );

    task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc(int n); repeat (n) @(negedge clk); endtask
    task automatic set_ab(logic a, logic b); ch_a = a; ch_b = b; cyc(1); endtask
    task automatic wr_cfg(logic sel, logic [7:0] v);
        cfg_sel = sel; cfg_wdata = v; cfg_wr = 1; cyc(1); cfg_wr = 0;
    endtask
    task automatic wr_dtr(logic [W-1:0] v); dtr_wdata = v; dtr_wr = 1; cyc(1); dtr_wr = 0; endtask
    task automatic do_clr();   cntr_clr = 1;  cyc(1); cntr_clr = 0;  endtask
    task automatic do_load();  cntr_load = 1; cyc(1); cntr_load = 0; endtask
    task automatic do_latch(); otr_load = 1;  cyc(1); otr_load = 0;  endtask
    task automatic do_fclr();  flag_clr = 1;  cyc(1); flag_clr = 0;  endtask
    task automatic step_sd(logic down); set_ab(1, down); set_ab(0, down); endtask
    task automatic steps(logic down, int n); for (int i = 0; i < n; i++) step_sd(down); endtask
    task automatic qmove(bit fwd, int n);
        for (int i = 0; i < n; i++) begin
            ph = fwd ? (ph + 1) % 4 : (ph + 3) % 4;
            set_ab(ph == 1 || ph == 2, ph == 2 || ph == 3);
        end
    endtask

    task automatic t_reset();
        chk("reset cnt", cnt_val, 0);
        chk("reset otr", otr_val, 0);
        chk("reset flags", {flag_idx, flag_cmp, flag_borrow, flag_carry}, 0);
    endtask

    task automatic t_stepdir();
        set_ab(1, 0); chk("R1 up step", cnt_val, 1);
        set_ab(0, 0); chk("R1 A fall ignored", cnt_val, 1);
        set_ab(0, 1); chk("R1 B change ignored", cnt_val, 1);
        set_ab(1, 1); chk("R1 down step", cnt_val, 0);
        set_ab(0, 0);
    endtask

    task automatic t_free();
        wr_cfg(1, 8'h18); do_clr();
        step_sd(1); chk("R5 8b borrow wrap", cnt_val, 32'hFF);
        chk("R5 borrow flag", flag_borrow, 1);
        do_fclr();
        step_sd(0); chk("R5 8b carry wrap", cnt_val, 0);
        chk("R5 carry flag", flag_carry, 1);
        chk("R5 borrow quiet", flag_borrow, 0);
        wr_cfg(1, 8'h19); do_clr();
        step_sd(1); chk("R5 16b wrap", cnt_val, 32'hFFFF);
        wr_cfg(1, 8'h18);
    endtask

    task automatic t_quad();
        set_ab(0, 0); ph = 0;
        wr_cfg(0, 8'h01); do_clr();
        qmove(1, 4); chk("R2 x1 fwd cycle", cnt_val, 1);
        qmove(0, 4); chk("R2 x1 rev cycle", cnt_val, 0);
        wr_cfg(0, 8'h02); do_clr();
        qmove(1, 4); chk("R3 x2 fwd cycle", cnt_val, 2);
        wr_cfg(0, 8'h03); do_clr();
        qmove(1, 4); chk("R4 x4 fwd cycle", cnt_val, 4);
        qmove(0, 1); chk("R4 x4 rev edge", cnt_val, 3);
        qmove(1, 1);
        set_ab(1, 1); set_ab(0, 0); chk("R4 illegal ignored", cnt_val, 4);
    endtask

    task automatic t_single();
        wr_cfg(0, 8'h04); do_clr(); do_fclr();
        step_sd(1); chk("R6 borrow", cnt_val, 32'hFF);
        chk("R6 borrow flag", flag_borrow, 1);
        step_sd(1); step_sd(0); chk("R6 halted", cnt_val, 32'hFF);
        do_clr(); step_sd(0); chk("R6 resumes", cnt_val, 1);
    endtask

    task automatic t_range();
        wr_cfg(0, 8'h08); wr_dtr(5); do_clr();
        steps(0, 7); chk("R7 top held", cnt_val, 5);
        steps(1, 7); chk("R7 bottom held", cnt_val, 0);
    endtask

    task automatic t_modulo();
        wr_cfg(0, 8'h0C); wr_dtr(3); do_clr();
        steps(0, 4); chk("R8 up rollover", cnt_val, 0);
        steps(0, 1); chk("R8 next", cnt_val, 1);
        steps(1, 2); chk("R8 down rollover", cnt_val, 3);
    endtask

    task automatic t_compare();
        wr_cfg(1, 8'h20); do_clr(); do_fclr();
        steps(0, 2); set_ab(1, 0);
        chk("R12 cnt at preset", cnt_val, 3);
        chk("R12 cmp not yet", flag_cmp, 0);
        cyc(1); chk("R12 cmp set", flag_cmp, 1);
        set_ab(0, 0);
        wr_cfg(1, 8'h00); do_fclr(); cyc(2);
        chk("R12 cmp disabled", flag_cmp, 0);
        wr_cfg(1, 8'h18); do_fclr();
        step_sd(0); chk("R12 carry set", flag_carry, 1);
        step_sd(0); chk("R12 carry sticky", flag_carry, 1);
        do_fclr(); chk("R12 carry cleared", flag_carry, 0);
    endtask

    task automatic t_enable();
        wr_cfg(0, 8'h00); wr_cfg(1, 8'h04);
        step_sd(0); chk("R11 disabled hold", cnt_val, 1);
        wr_cfg(1, 8'h00);
        step_sd(0); chk("R11 re-enabled", cnt_val, 2);
    endtask

    task automatic t_index();
        wr_dtr(9); wr_cfg(0, 8'h10); do_clr();
        ch_idx = 1; cyc(1); chk("R10 sync not yet", cnt_val, 0);
        cyc(1); chk("R9 load on index", cnt_val, 9);
        ch_idx = 0; cyc(1);
        wr_cfg(0, 8'h63);
        ch_idx = 1; cyc(1); chk("R10 async clear", cnt_val, 0);
        ch_idx = 0; cyc(1);
        wr_cfg(0, 8'h60); step_sd(0);
        ch_idx = 1; cyc(1); chk("R10 async ignored", cnt_val, 1);
        cyc(1); chk("R9 clear on index", cnt_val, 0);
        ch_idx = 0; cyc(1);
        wr_cfg(0, 8'h30); wr_cfg(1, 8'h40); do_fclr();
        steps(0, 2);
        ch_idx = 1; cyc(2);
        chk("R9 latch on index", otr_val, 2);
        chk("R9 count kept", cnt_val, 2);
        chk("R12 index flag", flag_idx, 1);
        ch_idx = 0; cyc(1);
    endtask

    task automatic t_regs();
        step_sd(0); do_latch(); chk("R14 otr_load", otr_val, 3);
        wr_dtr(32'h2A); do_load(); chk("R14 cntr_load", cnt_val, 32'h2A);
        do_clr(); chk("R14 cntr_clr", cnt_val, 0);
    endtask

    task automatic t_div2();
        wr_cfg(0, 8'h80); do_clr();
        ch_a = 1; cyc(2); chk("R13 div2 first", cnt_val, 1);
        ch_a = 0; cyc(2);
        ch_a = 1; cyc(2); chk("R13 div2 second", cnt_val, 2);
        ch_a = 0; cyc(2); chk("R13 div2 fall", cnt_val, 2);
    endtask

    initial begin
        cyc(3); rst_n = 1; cyc(1);
        t_reset(); t_stepdir(); t_free(); t_quad(); t_single();
        t_range(); t_modulo(); t_compare(); t_enable(); t_index();
        t_regs(); t_div2();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule